// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave (SMBus-compatible electrical and framing rules) that holds a small bank of 8-bit configuration registers for a clock generator: output-enable bytes, a spread-spectrum control byte and a fixed identification byte. A host reaches the bank through a fixed 7-bit device address. Every transfer names a starting register through a command code. Single-byte access and byte-count-prefixed block access are both available, for both writes and reads.

The serial lines are sampled with the system clock. Start and stop conditions, address matching, acknowledge generation and the bit shifting are all handled on that clock. The slave only ever pulls SDA low, through an output-enable pin, and never drives it high. The register contents leave the block as a flat bus and as two decoded spread-setting bits, so the surrounding clock logic can use them directly.

Top module: `smb_cfg_bank`

## Requirements
- R1: After reset, every register other than the spread register (index 5) and the identification register (index 7) holds 8'hFF, the spread register holds 8'h00, the identification register holds ID_VALUE, and `sda_oe_o` is low.
- R2: The slave answers only to the 7-bit address 7'h69, sent as byte 8'hD2 to write or 8'hD3 to read. For any other address it leaves SDA released during the acknowledge bit, and the transfer changes no register.
- R3: After a matching address, the slave acknowledges every byte it receives (address, command, count and data) by holding SDA low through the ninth SCL pulse.
- R4: In the command byte, bit 7 = 1 selects byte access and bit 7 = 0 selects block access. Bits [2:0] give the index of the starting register.
- R5: A byte write has the form start, 8'hD2, command, data, stop. It stores the data at the commanded index.
- R6: A byte read has the form start, 8'hD2, command, repeated start, 8'hD3, then one byte returned by the slave and a not-acknowledge from the master. The returned byte is the register at the commanded index.
- R7: In a block write, a count byte follows the command. The data bytes then go to consecutive indices from the commanded one, wrapping modulo 8.
- R8: In a block read, the slave first returns a count byte equal to 8. It then returns consecutive registers from the commanded index, wrapping modulo 8, for as long as the master acknowledges.
- R9: The identification register at index 7 is read-only. It always reads ID_VALUE, with the revision code in bits [7:4] and the vendor code in bits [3:0].
- R10: In the spread register, bit 0 selects the spread amount (0 = -0.5 %, 1 = -1.0 % peak-to-peak) and drives `spread_wide_o`. Bit 1 selects the spread type (0 = down, 1 = center) and drives `spread_center_o`. Bits [7:2] are reserved and always read 0, whatever is written to them.
- R11: The slave changes SDA only while SCL is low. A stop releases SDA and ends the transfer. A start seen at any point begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cfg_o | output | NREG*8 | All register bytes, index i at bits [8i+7:8i] |
| spread_wide_o | output | 1 | Spread amount select from the spread register |
| spread_center_o | output | 1 | Spread type select from the spread register |

## Verification
The hardest case to reach from the ports is a block transfer that wraps past the top index and crosses the read-only identification register in the middle of a burst. That case needs the right start index, the right byte count and a long enough sequence of master acknowledges. The bench reaches it with directed block writes and reads that start near the top of the bank. It mixes in randomly sized block and byte transfers at random indices, and keeps a write-mask model that decides what each register should read back.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } smb_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_CNT,
    K_DATA
  } rx_kind_e;

  function automatic logic [7:0] reg_wmask(input int idx, input int spread_idx, input int id_idx);
    if (idx == id_idx)          return 8'h00;
    else if (idx == spread_idx) return 8'h03;
    else                        return 8'hFF;
  endfunction

  function automatic logic [7:0] reg_reset(input int idx, input int spread_idx, input int id_idx,
                                           input logic [7:0] id_value);
    if (idx == id_idx)          return id_value;
    else if (idx == spread_idx) return 8'h00;
    else                        return 8'hFF;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_ff[SYNC_STAGES-1];
      sda_p <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int         NREG       = 8,
  parameter int         SPREAD_IDX = 5,
  parameter int         ID_IDX     = 7,
  parameter logic [7:0] ID_VALUE   = 8'h2A,
  localparam int        IW         = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IW-1:0]   waddr,
  input  logic [7:0]      wdata,
  input  logic [IW-1:0]   raddr,
  output logic [7:0]      rdata,
  output logic [NREG*8-1:0] cfg_flat
);
  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [7:0] WM = reg_wmask(g, SPREAD_IDX, ID_IDX);
      localparam logic [7:0] RV = reg_reset(g, SPREAD_IDX, ID_IDX, ID_VALUE);
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else if (we && waddr == IW'(g)) q <= (q & ~WM) | (wdata & WM);
      end
      assign cfg_flat[g*8 +: 8] = q;
    end
  endgenerate

  assign rdata = cfg_flat[raddr*8 +: 8];
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 8,
  localparam int        IW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [7:0]    rdata,
  output logic [IW-1:0] raddr,
  output logic          we,
  output logic [IW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          sda_oe
);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  smb_state_e    st;
  rx_kind_e      kind;
  logic [7:0]    sh, txsh;
  logic [3:0]    cnt;
  logic [IW-1:0] ptr;
  logic          block_q, ack_tx, rd_first, nack_q;
  logic [7:0]    next_tx;

  assign next_tx = rd_first ? CNT_BYTE : rdata;
  assign raddr   = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind     <= K_ADDR;
      sh       <= '0;
      txsh     <= '0;
      cnt      <= '0;
      ptr      <= '0;
      block_q  <= 1'b0;
      ack_tx   <= 1'b0;
      rd_first <= 1'b0;
      nack_q   <= 1'b0;
      we       <= 1'b0;
      waddr    <= '0;
      wdata    <= '0;
      sda_oe   <= 1'b0;
    end else begin
      we <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st     <= ST_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                K_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    st       <= ST_ACK;
                    sda_oe   <= 1'b1;
                    ack_tx   <= sh[0];
                    rd_first <= block_q;
                    kind     <= K_CMD;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_CMD: begin
                  ptr     <= sh[IW-1:0];
                  block_q <= ~sh[7];
                  kind    <= sh[7] ? K_DATA : K_CNT;
                  ack_tx  <= 1'b0;
                  st      <= ST_ACK;
                  sda_oe  <= 1'b1;
                end
                K_CNT: begin
                  kind   <= K_DATA;
                  st     <= ST_ACK;
                  sda_oe <= 1'b1;
                end
                default: begin
                  we     <= 1'b1;
                  waddr  <= ptr;
                  wdata  <= sh;
                  ptr    <= ptr + 1'b1;
                  st     <= ST_ACK;
                  sda_oe <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ack_tx) begin
                txsh     <= next_tx;
                sda_oe   <= ~next_tx[7];
                rd_first <= 1'b0;
                if (!rd_first) ptr <= ptr + 1'b1;
                st       <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_MACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (nack_q) begin
                st <= ST_IDLE;
              end else begin
                txsh     <= next_tx;
                sda_oe   <= ~next_tx[7];
                rd_first <= 1'b0;
                if (!rd_first) ptr <= ptr + 1'b1;
                st       <= ST_TX;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         SPREAD_IDX  = 5,
  parameter int         ID_IDX      = 7,
  parameter logic [7:0] ID_VALUE    = 8'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] cfg_o,
  output logic              spread_wide_o,
  output logic              spread_center_o
);
  localparam int IW = $clog2(NREG);

  logic          scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;
  logic          reg_we;
  logic [IW-1:0] reg_waddr, reg_raddr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic [7:0]    id_byte, spread_byte;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_s), .stop_det(stop_s)
  );

  smb_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_s), .stop_det(stop_s), .sda_s(sda_s),
    .rdata(reg_rdata), .raddr(reg_raddr), .we(reg_we), .waddr(reg_waddr),
    .wdata(reg_wdata), .sda_oe(sda_oe_o)
  );

  smb_cfg_regs #(.NREG(NREG), .SPREAD_IDX(SPREAD_IDX), .ID_IDX(ID_IDX), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .cfg_flat(cfg_o)
  );

  assign id_byte         = cfg_o[ID_IDX*8 +: 8];
  assign spread_byte     = cfg_o[SPREAD_IDX*8 +: 8];
  assign spread_wide_o   = spread_byte[0];
  assign spread_center_o = spread_byte[1];
endmodule

// File: rtl/smb_cfg_bank_chk.sv
module smb_cfg_bank_chk #(
  parameter int         NREG       = 8,
  parameter int         SPREAD_IDX = 5,
  localparam int        IW         = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          stop_s,
  input logic          sda_oe,
  input logic          we,
  input logic [IW-1:0] waddr,
  input logic [7:0]    wdata,
  input logic [7:0]    id_byte,
  input logic [7:0]    spread_byte
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_s |=> !sda_oe); // R11
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
    we |-> sda_oe); // R3
  AST_ID_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(id_byte)); // R9
  AST_SPREAD_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == IW'(SPREAD_IDX)) |=> spread_byte == ($past(wdata) & 8'h03)); // R10
endmodule

bind smb_cfg_bank smb_cfg_bank_chk #(.NREG(NREG), .SPREAD_IDX(SPREAD_IDX)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_s(stop_s), .sda_oe(sda_oe_o),
  .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
  .id_byte(id_byte), .spread_byte(spread_byte)
);

// File: tb/test_smb_cfg_bank.sv
`timescale 1ns/1ps
module test_smb_cfg_bank;
  localparam int         Q     = 10;
  localparam logic [7:0] IDV   = 8'h2A;
  localparam int         NR    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_oe  = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [NR*8-1:0] cfg;
  logic sp_wide, sp_center;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_r [NR];
  logic [7:0] wbuf [16];

  always #2.5 clk = ~clk;
  assign sda_line = ~(m_oe | sda_oe);

  smb_cfg_bank i_smb_cfg_bank (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .cfg_o(cfg), .spread_wide_o(sp_wide), .spread_center_o(sp_center)
  );

  function automatic logic [7:0] wmask(input int i);
    if (i == 7) return 8'h00;
    if (i == 5) return 8'h03;
    return 8'hFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_oe = 1'b0; qw(); m_scl = 1'b1; qw(); m_oe = 1'b1; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_oe = 1'b1; qw(); m_scl = 1'b1; qw(); m_oe = 1'b0; qw(); qw();
  endtask

  task automatic bit_w(input logic b);
    m_oe = ~b; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bit_r(output logic b);
    m_oe = 1'b0; qw(); m_scl = 1'b1; qw(); b = sda_line; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic byte_w(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(ack_n);
  endtask

  task automatic byte_r(input logic nack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_r(b);
      d[i] = b;
    end
    bit_w(nack);
  endtask

  task automatic check_ports(input string req);
    for (int i = 0; i < NR; i++) check(req, cfg[i*8 +: 8], exp_r[i]);
  endtask

  // R4: cmd bit7=1 byte access, bit7=0 block access, bits[2:0] index
  task automatic do_write(input bit blk, input int idx, input int n);
    logic a;
    bus_start();
    byte_w(8'hD2, a); check("R2 address ack", a, 0);
    byte_w(blk ? 8'(idx) : (8'h80 | 8'(idx)), a); check("R3 R4 command ack", a, 0);
    if (blk) begin
      byte_w(8'(n), a); check("R7 count ack", a, 0);
    end
    for (int k = 0; k < n; k++) begin
      byte_w(wbuf[k], a); check("R3 data ack", a, 0);
      exp_r[(idx + k) % NR] = (exp_r[(idx + k) % NR] & ~wmask((idx + k) % NR)) |
                              (wbuf[k] & wmask((idx + k) % NR));
    end
    bus_stop();
  endtask

  task automatic do_read(input bit blk, input int idx, input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    byte_w(8'hD2, a); check("R2 address ack", a, 0);
    byte_w(blk ? 8'(idx) : (8'h80 | 8'(idx)), a); check("R3 R4 command ack", a, 0);
    bus_start();
    byte_w(8'hD3, a); check("R6 read address ack", a, 0);
    if (blk) begin
      byte_r(1'b0, d); check("R8 count byte", d, 8);
    end
    for (int k = 0; k < n; k++) begin
      byte_r(k == n - 1, d);
      check(blk ? "R8 block data" : "R6 byte data", d, exp_r[(idx + k) % NR]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a;
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < NR; i++) exp_r[i] = (i == 7) ? IDV : (i == 5) ? 8'h00 : 8'hFF;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 reset state
    check_ports("R1 reset value");
    check("R1 sda released", sda_oe, 0);

    // R2 wrong address: no ack, no change
    bus_start();
    byte_w(8'hD4, a); check("R2 foreign address nack", a, 1);
    byte_w(8'h80, a); check("R2 ignored byte nack", a, 1);
    byte_w(8'h00, a);
    bus_stop();
    check_ports("R2 no register change");

    // R5 byte write, R6 byte read
    wbuf[0] = 8'h5C; do_write(0, 2, 1);
    check("R5 byte write", cfg[2*8 +: 8], 8'h5C);
    do_read(0, 2, 1);

    // R9 identification read-only
    wbuf[0] = 8'h00; do_write(0, 7, 1);
    check("R9 id unchanged", cfg[7*8 +: 8], IDV);
    do_read(0, 7, 1);

    // R10 spread bits and reserved
    wbuf[0] = 8'hFF; do_write(0, 5, 1);
    check("R10 spread byte", cfg[5*8 +: 8], 8'h03);
    check("R10 wide", sp_wide, 1);
    check("R10 center", sp_center, 1);
    wbuf[0] = 8'hFE; do_write(0, 5, 1);
    check("R10 wide low", sp_wide, 0);
    check("R10 center high", sp_center, 1);
    do_read(0, 5, 1);

    // R7 block write wrapping across the id register
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(1, 6, 4);
    check_ports("R7 block wrap");
    // R8 block read wrapping
    do_read(1, 5, 5);

    // R11 stop mid-transfer returns to idle, then new transfer works
    bus_start();
    byte_w(8'hD2, a); check("R11 ack before stop", a, 0);
    bus_stop();
    check("R11 sda released after stop", sda_oe, 0);
    wbuf[0] = 8'hA5; do_write(0, 0, 1);
    check("R11 transfer after stop", cfg[7:0], 8'hA5);

    // random mix
    for (int t = 0; t < 24; t++) begin
      int op, idx, n;
      op  = int'($urandom % 4);
      idx = int'($urandom % NR);
      n   = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      case (op)
        0: do_write(0, idx, 1);
        1: do_write(1, idx, n);
        2: do_read(0, idx, 1);
        default: do_read(1, idx, n);
      endcase
      check_ports("R5 R7 random state");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule